// File: doc/BRIEF.md
# Branch Target Buffer Predictor

The block predicts branch destinations at fetch time and repairs fetch when a prediction turns out to be wrong. It holds a direct-mapped table selected by the instruction address. Each slot records a valid flag, the upper address bits of the branch that owns it, the last destination seen, and whether that branch was last taken. Every cycle, fetch presents an address. On a hit whose stored direction is taken, the block hands back the stored destination as the next fetch address. A miss, or a hit whose stored direction is not taken, continues sequentially.

Branches resolve late, in write-back. The pipeline returns the resolved address, the real direction and destination, and the prediction that fetch used for that branch. Every resolved branch writes its real outcome into its slot. When the prediction disagrees with the outcome, the block raises a redirect carrying the correct address on the next cycle. It also holds a flush signal for a fixed number of cycles (three by default) to squash the younger instructions already in flight. A correct prediction causes neither signal.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid: any lookup misses, `pred_taken` is 0, and `redirect_valid` and `flush` are 0.
- R2: A lookup miss predicts not taken, and `next_fetch_pc` is `fetch_pc + 4` (one instruction step of 2^OFS_W bytes).
- R3: A lookup whose slot is valid, has a matching tag and holds a taken direction sets `pred_hit` and `pred_taken`, and `next_fetch_pc` equals the stored destination.
- R4: A hit whose stored direction is not taken sets `pred_hit`, clears `pred_taken`, and gives `next_fetch_pc = fetch_pc + 4`.
- R5: The slot is chosen by address bits [9:2] and the tag is bits [31:10]. An address with the same slot bits but different tag bits misses.
- R6: Each resolved branch (`res_valid`) writes its actual direction and destination into its slot. A lookup of that address one cycle later returns the new contents.
- R7: A lookup in the same cycle as an update to the same slot returns the contents held before the update.
- R8: A resolved branch whose prediction matches its outcome produces no redirect and no flush. For a not-taken branch the destination fields are not compared.
- R9: A misprediction raises `redirect_valid` for exactly one cycle, on the cycle after resolution. `redirect_pc` is the resolved destination if taken, or `res_pc + 4` if not taken.
- R10: `flush` rises together with `redirect_valid` and stays high for exactly FLUSH_CYCLES (3) consecutive cycles.
- R11: A branch predicted taken and resolved taken to a different destination counts as a misprediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch lookup is requested this cycle |
| fetch_pc | input | ADDR_W | Address being fetched |
| pred_hit | output | 1 | Lookup found a valid slot with matching tag |
| pred_taken | output | 1 | Lookup predicts taken |
| pred_target | output | ADDR_W | Destination stored in the looked-up slot |
| next_fetch_pc | output | ADDR_W | Predicted next fetch address |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | ADDR_W | Address of the resolving branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | ADDR_W | Actual destination when taken |
| res_pred_taken | input | 1 | Direction fetch predicted for this branch |
| res_pred_target | input | ADDR_W | Destination fetch predicted for this branch |
| redirect_valid | output | 1 | One-cycle request to restart fetch |
| redirect_pc | output | ADDR_W | Address at which fetch restarts |
| flush | output | 1 | Squash younger in-flight instructions |

## Verification
The assertions assume that no branch resolves while `flush` is high, because the instructions that could resolve then are the ones being squashed. The flush-length and redirect checks rely on that. The stimulus keeps to it by sending at least three idle resolve cycles after every misprediction. The reported predicted direction and destination are taken as whatever fetch used, so the stimulus uses them freely to produce both agreeing and disagreeing outcomes, including stale destinations.

// File: rtl/btb_pkg.sv
package btb_pkg;

   typedef struct packed {
      logic valid;
      logic taken;
   } btb_flags_t;

   function automatic bit btb_is_pow2(input int value);
      return (value > 0) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
   import btb_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 256,
   parameter int TAG_W   = 22,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_hit,
   output logic              rd_taken,
   output logic [ADDR_W-1:0] rd_target,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_taken,
   input  logic [ADDR_W-1:0] wr_target
);

   btb_flags_t        flags_q  [ENTRIES];
   logic [TAG_W-1:0]  tag_q    [ENTRIES];
   logic [ADDR_W-1:0] target_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));

      // only the flags carry a reset: tag and target are meaningless while invalid
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q[e] <= '0;
         end else if (sel) begin
            flags_q[e].valid <= 1'b1;
            flags_q[e].taken <= wr_taken;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[e]    <= wr_tag;
            target_q[e] <= wr_target;
         end
      end
   end

   // read side is combinational from the registers, so a write in the same
   // cycle is only seen by the following lookup
   btb_flags_t rd_flags;
   always_comb begin
      rd_flags  = flags_q[rd_idx];
      rd_hit    = rd_flags.valid && (tag_q[rd_idx] == rd_tag);
      rd_taken  = rd_flags.taken;
      rd_target = target_q[rd_idx];
   end

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 2
) (
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_pc,
   input  logic              res_taken,
   input  logic [ADDR_W-1:0] res_target,
   input  logic              res_pred_taken,
   input  logic [ADDR_W-1:0] res_pred_target,
   output logic              mispredict,
   output logic [ADDR_W-1:0] correct_pc
);

   localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1} << OFS_W;

   logic dir_wrong;
   logic dest_wrong;

   always_comb begin
      dir_wrong  = res_taken != res_pred_taken;
      dest_wrong = res_taken && res_pred_taken && (res_target != res_pred_target);
      mispredict = res_valid && (dir_wrong || dest_wrong);
      correct_pc = res_taken ? res_target : (res_pc + STEP);
   end

endmodule

// File: rtl/btb_flush_ctrl.sv
module btb_flush_ctrl #(
   parameter int ADDR_W       = 32,
   parameter int FLUSH_CYCLES = 3,
   localparam int CNT_W       = $clog2(FLUSH_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mispredict,
   input  logic [ADDR_W-1:0] correct_pc,
   output logic              redirect_valid,
   output logic [ADDR_W-1:0] redirect_pc,
   output logic              flush
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
      end else begin
         redirect_valid <= mispredict;
         if (mispredict) redirect_pc <= correct_pc;
      end
   end

   if (FLUSH_CYCLES == 1) begin : g_single
      assign flush = redirect_valid;
   end else begin : g_counter
      logic [CNT_W-1:0] remain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                remain_q <= '0;
         else if (mispredict)       remain_q <= CNT_W'(FLUSH_CYCLES);
         else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
      end
      assign flush = remain_q != '0;
   end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
   import btb_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int ENTRIES      = 256,
   parameter int OFS_W        = 2,
   parameter int FLUSH_CYCLES = 3,
   localparam int IDX_W       = $clog2(ENTRIES),
   localparam int TAG_W       = ADDR_W - IDX_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_pc,
   output logic              pred_hit,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] pred_target,
   output logic [ADDR_W-1:0] next_fetch_pc,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_pc,
   input  logic              res_taken,
   input  logic [ADDR_W-1:0] res_target,
   input  logic              res_pred_taken,
   input  logic [ADDR_W-1:0] res_pred_target,
   output logic              redirect_valid,
   output logic [ADDR_W-1:0] redirect_pc,
   output logic              flush
);

   localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1} << OFS_W;

   if (!btb_is_pow2(ENTRIES)) begin : g_bad_entries
      $error("btb_predictor: ENTRIES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("btb_predictor: ADDR_W too small for ENTRIES and OFS_W");
   end
   if (FLUSH_CYCLES < 1) begin : g_bad_flush
      $error("btb_predictor: FLUSH_CYCLES must be at least 1");
   end

   logic              rd_hit;
   logic              rd_taken;
   logic [ADDR_W-1:0] rd_target;
   logic              mispredict;
   logic [ADDR_W-1:0] correct_pc;

   btb_store #(
      .ADDR_W (ADDR_W),
      .ENTRIES(ENTRIES),
      .TAG_W  (TAG_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (fetch_pc[OFS_W +: IDX_W]),
      .rd_tag   (fetch_pc[ADDR_W-1 -: TAG_W]),
      .rd_hit   (rd_hit),
      .rd_taken (rd_taken),
      .rd_target(rd_target),
      .wr_en    (res_valid),
      .wr_idx   (res_pc[OFS_W +: IDX_W]),
      .wr_tag   (res_pc[ADDR_W-1 -: TAG_W]),
      .wr_taken (res_taken),
      .wr_target(res_target)
   );

   btb_resolve #(
      .ADDR_W(ADDR_W),
      .OFS_W (OFS_W)
   ) u_resolve (
      .res_valid      (res_valid),
      .res_pc         (res_pc),
      .res_taken      (res_taken),
      .res_target     (res_target),
      .res_pred_taken (res_pred_taken),
      .res_pred_target(res_pred_target),
      .mispredict     (mispredict),
      .correct_pc     (correct_pc)
   );

   btb_flush_ctrl #(
      .ADDR_W      (ADDR_W),
      .FLUSH_CYCLES(FLUSH_CYCLES)
   ) u_flush (
      .clk           (clk),
      .rst_n         (rst_n),
      .mispredict    (mispredict),
      .correct_pc    (correct_pc),
      .redirect_valid(redirect_valid),
      .redirect_pc   (redirect_pc),
      .flush         (flush)
   );

   always_comb begin
      pred_hit      = fetch_valid && rd_hit;
      pred_taken    = pred_hit && rd_taken;
      pred_target   = rd_target;
      next_fetch_pc = pred_taken ? rd_target : (fetch_pc + STEP);
   end

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
   parameter int ADDR_W       = 32,
   parameter int ENTRIES      = 256,
   parameter int OFS_W        = 2,
   parameter int FLUSH_CYCLES = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_valid,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic              pred_hit,
   input logic              pred_taken,
   input logic [ADDR_W-1:0] pred_target,
   input logic [ADDR_W-1:0] next_fetch_pc,
   input logic              res_valid,
   input logic [ADDR_W-1:0] res_pc,
   input logic              res_taken,
   input logic [ADDR_W-1:0] res_target,
   input logic              res_pred_taken,
   input logic [ADDR_W-1:0] res_pred_target,
   input logic              redirect_valid,
   input logic [ADDR_W-1:0] redirect_pc,
   input logic              flush
);

   localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1} << OFS_W;

   int unsigned run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_len <= 0;
      else if (flush) run_len <= run_len + 1;
      else            run_len <= 0;
   end

   assert_miss_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !pred_hit) |-> (!pred_taken && next_fetch_pc == fetch_pc + STEP));

   assert_taken_uses_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> (pred_hit && next_fetch_pc == pred_target));

   assert_correct_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken == res_pred_taken &&
       (!res_taken || res_target == res_pred_target)) |=> !redirect_valid);

   assert_redirect_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> ($past(res_valid) &&
         redirect_pc == ($past(res_taken) ? $past(res_target) : $past(res_pc) + STEP)));

   assert_redirect_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> !redirect_valid);

   assert_flush_with_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> flush);

   assert_flush_not_long_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (run_len < FLUSH_CYCLES));

   assert_flush_full_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flush) |-> (run_len == FLUSH_CYCLES));

   assert_target_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken && res_pred_taken && res_target != res_pred_target)
      |=> (redirect_valid && redirect_pc == $past(res_target)));

endmodule

bind btb_predictor btb_predictor_chk #(
   .ADDR_W      (ADDR_W),
   .ENTRIES     (ENTRIES),
   .OFS_W       (OFS_W),
   .FLUSH_CYCLES(FLUSH_CYCLES)
) u_chk (.*);

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_hit, pred_taken;
   logic [31:0] pred_target, next_fetch_pc;
   logic        res_valid = 1'b0;
   logic [31:0] res_pc = '0;
   logic        res_taken = 1'b0;
   logic [31:0] res_target = '0;
   logic        res_pred_taken = 1'b0;
   logic [31:0] res_pred_target = '0;
   logic        redirect_valid;
   logic [31:0] redirect_pc;
   logic        flush;

   always #2 clk = ~clk;   // 250 MHz

   btb_predictor u_btb_predictor (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .pred_hit(pred_hit), .pred_taken(pred_taken),
      .pred_target(pred_target), .next_fetch_pc(next_fetch_pc),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_target(res_target), .res_pred_taken(res_pred_taken),
      .res_pred_target(res_pred_target),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .flush(flush)
   );

   typedef struct {
      int          cyc;
      bit          is_flow;
      bit          e_hit;
      bit          e_taken;
      logic [31:0] e_next;
      bit          e_redir;
      logic [31:0] e_rpc;
      bit          e_flush;
      string       req;
   } item_t;

   item_t q[$];
   int ncyc = 0;
   int compared = 0;
   int mismatched = 0;

   bit          m_valid [256];
   logic [21:0] m_tag   [256];
   logic [31:0] m_tgt   [256];
   bit          m_taken [256];

   always @(posedge clk) ncyc <= ncyc + 1;

   // monitor: samples 1 ns after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == ncyc) begin
               compared++;
               if (!q[i].is_flow) begin
                  if (pred_hit !== q[i].e_hit || pred_taken !== q[i].e_taken ||
                      next_fetch_pc !== q[i].e_next) begin
                     mismatched++;
                     $display("FAIL %s lookup: hit=%0b taken=%0b next=%h expected hit=%0b taken=%0b next=%h",
                              q[i].req, pred_hit, pred_taken, next_fetch_pc,
                              q[i].e_hit, q[i].e_taken, q[i].e_next);
                  end
               end else begin
                  if (redirect_valid !== q[i].e_redir || flush !== q[i].e_flush ||
                      (q[i].e_redir && redirect_pc !== q[i].e_rpc)) begin
                     mismatched++;
                     $display("FAIL %s flow: redirect=%0b pc=%h flush=%0b expected redirect=%0b pc=%h flush=%0b",
                              q[i].req, redirect_valid, redirect_pc, flush,
                              q[i].e_redir, q[i].e_rpc, q[i].e_flush);
                  end
               end
               q.delete(i);
            end
         end
      end
   end

   function automatic void push_flow(int cyc, bit redir, logic [31:0] rpc, bit fl, string rq);
      item_t it;
      it = '{cyc: cyc, is_flow: 1'b1, e_hit: 1'b0, e_taken: 1'b0, e_next: '0,
             e_redir: redir, e_rpc: rpc, e_flush: fl, req: rq};
      q.push_back(it);
   endfunction

   // driver: one cycle of lookup and optional resolve
   task automatic step(input bit fv, input logic [31:0] fpc,
                       input bit rv, input logic [31:0] rpc, input bit rtk,
                       input logic [31:0] rtgt, input bit rpt, input logic [31:0] rptgt,
                       input string rq);
      item_t it;
      bit    hit, tk, mis;
      int    li, ri;
      @(negedge clk);
      fetch_valid = fv; fetch_pc = fpc;
      res_valid = rv; res_pc = rpc; res_taken = rtk; res_target = rtgt;
      res_pred_taken = rpt; res_pred_target = rptgt;
      li  = int'(fpc[9:2]);
      hit = fv && m_valid[li] && (m_tag[li] == fpc[31:10]);
      tk  = hit && m_taken[li];
      it = '{cyc: ncyc, is_flow: 1'b0, e_hit: hit, e_taken: tk,
             e_next: tk ? m_tgt[li] : fpc + 32'd4,
             e_redir: 1'b0, e_rpc: '0, e_flush: 1'b0, req: rq};
      q.push_back(it);
      if (rv) begin
         mis = (rtk != rpt) || (rtk && rpt && rtgt != rptgt);
         if (mis) begin
            push_flow(ncyc + 1, 1'b1, rtk ? rtgt : rpc + 32'd4, 1'b1, {rq, " R9 R10"});
            push_flow(ncyc + 2, 1'b0, '0, 1'b1, {rq, " R10"});
            push_flow(ncyc + 3, 1'b0, '0, 1'b1, {rq, " R10"});
            push_flow(ncyc + 4, 1'b0, '0, 1'b0, {rq, " R10"});
         end else begin
            push_flow(ncyc + 1, 1'b0, '0, 1'b0, {rq, " R8"});
         end
         ri = int'(rpc[9:2]);
         m_valid[ri] = 1'b1; m_tag[ri] = rpc[31:10];
         m_tgt[ri] = rtgt; m_taken[ri] = rtk;
      end
   endtask

   task automatic look(input logic [31:0] fpc, input string rq);
      step(1'b1, fpc, 1'b0, '0, 1'b0, '0, 1'b0, '0, rq);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_taken[i] = 1'b0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset, quiet control outputs
      look(32'h0000_1000, "R1 R2");
      push_flow(ncyc, 1'b0, '0, 1'b0, "R1");

      // first resolve: miss predicted not taken, actually taken -> mispredict
      step(1'b1, 32'h0000_1000, 1'b1, 32'h0000_1000, 1'b1, 32'h0000_2000,
           1'b0, 32'h0, "R9");
      look(32'h0000_1000, "R3 R6");
      look(32'h0000_1400, "R5");     // same slot bits, different tag
      look(32'h0000_1000, "R3");

      // correct taken prediction, lookup same slot
      step(1'b1, 32'h0000_1000, 1'b1, 32'h0000_1000, 1'b1, 32'h0000_2000,
           1'b1, 32'h0000_2000, "R8 R3");
      look(32'h0000_1004, "R2");

      // taken to a new destination while predicted old one; same-cycle lookup sees old
      step(1'b1, 32'h0000_1000, 1'b1, 32'h0000_1000, 1'b1, 32'h0000_3000,
           1'b1, 32'h0000_2000, "R11 R7");
      look(32'h0000_1000, "R6");
      look(32'h0000_1000, "R6");
      look(32'h0000_1000, "R6");

      // predicted taken, resolved not taken
      step(1'b1, 32'h0000_1000, 1'b1, 32'h0000_1000, 1'b0, 32'h0000_3000,
           1'b1, 32'h0000_3000, "R9 R7");
      look(32'h0000_1000, "R4 R6");
      look(32'h0000_1000, "R4");
      look(32'h0000_1000, "R4");

      // correct not-taken with a stale destination field: fields ignored
      step(1'b0, 32'h0, 1'b1, 32'h0000_5550, 1'b0, 32'h0000_7777,
           1'b0, 32'h0000_1234, "R8");
      look(32'h0000_5550, "R4");
      step(1'b0, 32'h0000_5550, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R2");

      // fill several slots with taken branches, then look them up
      for (int k = 0; k < 8; k++) begin
         step(1'b0, 32'h0, 1'b1, 32'h0000_8000 + 32'(k * 4), 1'b1,
              32'h0001_0000 + 32'(k * 16), 1'b0, 32'h0, "R9 fill");
         look(32'h0000_8000 + 32'(k * 4), "R3 R6");
         look(32'h0000_9000, "R5");
         look(32'h0000_8000 + 32'(k * 4), "R3");
      end
      for (int k = 0; k < 8; k++) look(32'h0000_8000 + 32'(k * 4), "R3");

      repeat (6) look(32'h0000_0040, "R2");
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
         compared++;
         mismatched++;
         $display("FAIL R9 scoreboard: %0d items left, expected 0", q.size());
      end
      report();
   end

endmodule